// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits between a processor's register writes and an embedded flash array and decides when an erase may begin. Software first arms an erase by writing a precondition register: the page-address register for a single-page erase, or the mass-erase enable bit for a whole-array erase. It then writes a magic byte to the command register. A matching command with a valid precondition produces a one-cycle start pulse toward the array. The pulse comes with the erase kind and the page number, and the block then reports busy until the array answers with a done pulse.

Every arm is single-use, so an accepted erase consumes its precondition and software must write it again before the next erase of that kind. A mass erase additionally requires the debug port to be enabled at the moment the command is written. Commands with a wrong byte value, commands without a valid precondition, and commands written while an erase is still running start nothing and clear nothing. The last byte written to the command register is always available for read-back.

Top module: `flash_erase_seq`

## Requirements
- R1: Writing 8'h55 to the command register (`wr_sel` = 2'b00) while the page arm is set and the block is idle starts a page erase. On the clock edge that captures the write, `fl_start` and `busy` go high, `fl_mass` is 0, and `fl_page` carries the armed page number.
- R2: Writing 8'hAA to the command register while the mass arm is set, `debug_en` is 1 and the block is idle starts a mass erase, with `fl_start` and `busy` high and `fl_mass` at 1.
- R3: A command byte other than 8'h55 or 8'hAA starts nothing and leaves both arm flags unchanged.
- R4: A page-address write (`wr_sel` = 2'b01) takes the page number from `wr_data[5:0]`, covering pages 0 to 63, and sets the page arm. Without that arm, 8'h55 starts nothing.
- R5: A mass-enable write (`wr_sel` = 2'b10) sets the mass arm from `wr_data[0]`, and a 0 clears it. 8'hAA is rejected when the mass arm is clear or `debug_en` is 0, and a rejected 8'hAA leaves the mass arm set.
- R6: An accepted page erase clears the page arm, and an accepted mass erase clears the mass arm. Each arm is consumed by exactly one erase and leaves the other arm untouched.
- R7: After reset `busy`, `fl_start` and `fl_mass` are 0, `fl_page` is 0, `cmd_rdata` is 8'h00, and both arm flags are clear.
- R8: A command written while `busy` is high starts nothing and leaves both arm flags as they were.
- R9: `fl_start` is high for exactly one cycle per accepted erase. `busy` stays high from the accept edge until the edge that samples `fl_done` high and falls on that edge. `fl_done` while idle has no effect.
- R10: `cmd_rdata` holds the last byte written to the command register, whether or not the command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 00 command, 01 page address, 10 mass enable, 11 none |
| wr_data | input | 8 | Write data |
| debug_en | input | 1 | Debug port enabled; gates mass erase |
| fl_done | input | 1 | Flash array reports erase complete |
| fl_start | output | 1 | One-cycle erase start pulse to the array |
| fl_mass | output | 1 | Erase kind: 1 mass, 0 page |
| fl_page | output | 6 | Page number for a page erase |
| busy | output | 1 | Erase in progress |
| cmd_rdata | output | 8 | Read-back of the last command byte |

## Verification
The checker watches several rules on every cycle. The start pulse lasts a single cycle and coincides with the rising edge of busy. Busy holds until done and drops right after it. No start follows a busy cycle, every page start was preceded by an armed page and a 0x55 write, and every mass start by debug enable and a 0xAA write. Only the bench scenarios can show the rejections, because a rejected command leaves no mark on any signal: wrong bytes, missing arms, a cleared mass enable and commands during busy each have to be followed by a valid command. They likewise show that arms survive a rejection and are consumed by an acceptance, and that the page number and read-back byte are correct.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam int PAGE_AW = 6;
    localparam int DATA_W  = 8;

    localparam logic [DATA_W-1:0] CMD_PAGE_ERASE = 8'h55;
    localparam logic [DATA_W-1:0] CMD_MASS_ERASE = 8'hAA;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'b00,
        SEL_PAGE = 2'b01,
        SEL_MEEN = 2'b10,
        SEL_NONE = 2'b11
    } reg_sel_e;

    typedef enum logic {
        KIND_PAGE = 1'b0,
        KIND_MASS = 1'b1
    } erase_kind_e;

    typedef struct packed {
        logic                valid;
        erase_kind_e         kind;
        logic [PAGE_AW-1:0]  page;
    } erase_req_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_START = 2'b01,
        ST_WAIT  = 2'b10
    } seq_state_e;

    function automatic erase_kind_e byte_kind(input logic [DATA_W-1:0] b);
        return (b == CMD_MASS_ERASE) ? KIND_MASS : KIND_PAGE;
    endfunction

    function automatic logic is_erase_byte(input logic [DATA_W-1:0] b);
        return (b == CMD_PAGE_ERASE) || (b == CMD_MASS_ERASE);
    endfunction

endpackage

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
    import fe_pkg::*;
(
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                busy,
    input  logic                debug_en,
    input  logic                page_armed,
    input  logic                mass_armed,
    input  logic [PAGE_AW-1:0]  page_q,
    output logic                cmd_wr,
    output logic                set_page,
    output logic                set_meen,
    output erase_req_t          req
);
    reg_sel_e    sel;
    erase_kind_e kind;
    logic        precond_ok;

    always_comb begin
        sel      = reg_sel_e'(wr_sel);
        cmd_wr   = wr_en && (sel == SEL_CMD);
        set_page = wr_en && (sel == SEL_PAGE);
        set_meen = wr_en && (sel == SEL_MEEN);
        kind     = byte_kind(wr_data);
        if (kind == KIND_MASS) begin
            precond_ok = mass_armed && debug_en;
        end else begin
            precond_ok = page_armed;
        end
        req.valid = cmd_wr && !busy && is_erase_byte(wr_data) && precond_ok;
        req.kind  = kind;
        req.page  = page_q;
    end
endmodule

// File: rtl/fe_arm_regs.sv
module fe_arm_regs
    import fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                set_page,
    input  logic [PAGE_AW-1:0]  page_in,
    input  logic                set_meen,
    input  logic                meen_in,
    input  logic                consume_page,
    input  logic                consume_mass,
    output logic                page_armed,
    output logic                mass_armed,
    output logic [PAGE_AW-1:0]  page_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page_armed <= 1'b0;
            page_q     <= '0;
        end else if (set_page) begin
            page_armed <= 1'b1;
            page_q     <= page_in;
        end else if (consume_page) begin
            page_armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mass_armed <= 1'b0;
        end else if (set_meen) begin
            mass_armed <= meen_in;
        end else if (consume_mass) begin
            mass_armed <= 1'b0;
        end
    end
endmodule

// File: rtl/fe_erase_fsm.sv
module fe_erase_fsm
    import fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  erase_req_t          req,
    input  logic                fl_done,
    output logic                busy,
    output logic                fl_start,
    output logic                fl_mass,
    output logic [PAGE_AW-1:0]  fl_page
);
    seq_state_e state;
    erase_req_t active;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            active <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req.valid) begin
                        state  <= ST_START;
                        active <= req;
                    end
                end
                ST_START, ST_WAIT: begin
                    if (fl_done) begin
                        state        <= ST_IDLE;
                        active.valid <= 1'b0;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign fl_start = (state == ST_START);
    assign fl_mass  = (active.kind == KIND_MASS);
    assign fl_page  = active.page;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                debug_en,
    input  logic                fl_done,
    output logic                fl_start,
    output logic                fl_mass,
    output logic [PAGE_AW-1:0]  fl_page,
    output logic                busy,
    output logic [DATA_W-1:0]   cmd_rdata
);
    logic               cmd_wr, set_page, set_meen;
    logic               page_armed, mass_armed;
    logic [PAGE_AW-1:0] page_q;
    erase_req_t         req;

    fe_cmd_decode u_decode (
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .busy       (busy),
        .debug_en   (debug_en),
        .page_armed (page_armed),
        .mass_armed (mass_armed),
        .page_q     (page_q),
        .cmd_wr     (cmd_wr),
        .set_page   (set_page),
        .set_meen   (set_meen),
        .req        (req)
    );

    fe_arm_regs u_arms (
        .clk          (clk),
        .rst          (rst),
        .set_page     (set_page),
        .page_in      (wr_data[PAGE_AW-1:0]),
        .set_meen     (set_meen),
        .meen_in      (wr_data[0]),
        .consume_page (req.valid && (req.kind == KIND_PAGE)),
        .consume_mass (req.valid && (req.kind == KIND_MASS)),
        .page_armed   (page_armed),
        .mass_armed   (mass_armed),
        .page_q       (page_q)
    );

    fe_erase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .fl_done  (fl_done),
        .busy     (busy),
        .fl_start (fl_start),
        .fl_mass  (fl_mass),
        .fl_page  (fl_page)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_rdata <= '0;
        end else if (cmd_wr) begin
            cmd_rdata <= wr_data;
        end
    end
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       debug_en,
    input logic       fl_done,
    input logic       fl_start,
    input logic       fl_mass,
    input logic       busy,
    input logic       page_armed,
    input logic       mass_armed
);
    a_r9_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fl_start |=> !fl_start);

    a_r9_start_with_busy: assert property (@(posedge clk) disable iff (rst)
        fl_start |-> busy);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !fl_done) |=> busy);

    a_r9_done_releases: assert property (@(posedge clk) disable iff (rst)
        (busy && fl_done) |=> !busy);

    a_r9_rise_has_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> fl_start);

    a_r8_no_start_after_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> !fl_start);

    a_r1_page_start_cause: assert property (@(posedge clk) disable iff (rst)
        (fl_start && !fl_mass) |-> ($past(wr_en) && $past(wr_sel) == 2'b00
                                    && $past(wr_data) == 8'h55 && $past(page_armed)));

    a_r2_mass_start_cause: assert property (@(posedge clk) disable iff (rst)
        (fl_start && fl_mass) |-> ($past(wr_en) && $past(wr_sel) == 2'b00
                                   && $past(wr_data) == 8'hAA && $past(mass_armed)
                                   && $past(debug_en)));

    a_r6_page_arm_consumed: assert property (@(posedge clk) disable iff (rst)
        (fl_start && !fl_mass) |-> !page_armed);

    a_r6_mass_arm_consumed: assert property (@(posedge clk) disable iff (rst)
        (fl_start && fl_mass) |-> !mass_armed);
endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .debug_en   (debug_en),
    .fl_done    (fl_done),
    .fl_start   (fl_start),
    .fl_mass    (fl_mass),
    .busy       (busy),
    .page_armed (page_armed),
    .mass_armed (mass_armed)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b11;
    logic [7:0] wr_data = 8'h00;
    logic       debug_en = 1'b0;
    logic       fl_done = 1'b0;
    logic       fl_start, fl_mass, busy;
    logic [5:0] fl_page;
    logic [7:0] cmd_rdata;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // bench model of the requirements
    bit         m_page_arm = 0;
    bit         m_mass_arm = 0;
    logic [5:0] m_page = 0;
    logic [7:0] m_cmd = 0;

    always #4 clk = ~clk;

    flash_erase_seq i_flash_erase_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .debug_en(debug_en), .fl_done(fl_done), .fl_start(fl_start),
        .fl_mass(fl_mass), .fl_page(fl_page), .busy(busy), .cmd_rdata(cmd_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 0 = reject, 1 = page erase, 2 = mass erase
    function automatic int expect_accept(input logic [7:0] b, input bit bsy);
        if (bsy) return 0;
        if (b == 8'h55 && m_page_arm) return 1;
        if (b == 8'hAA && m_mass_arm && debug_en) return 2;
        return 0;
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11;
    endtask

    task automatic arm_page(input logic [5:0] p);
        wr(2'b01, {2'b00, p});
        m_page_arm = 1; m_page = p;
    endtask

    task automatic set_meen(input bit v);
        wr(2'b10, {7'd0, v});
        m_mass_arm = v;
    endtask

    // issue a command while idle and check the outcome
    task automatic cmd(input logic [7:0] b, input string req);
        int e;
        e = expect_accept(b, 1'b0);
        wr(2'b00, b);
        m_cmd = b;
        chk({req, " cmd_rdata"}, cmd_rdata, b);
        chk({req, " start"}, fl_start, e != 0);
        chk({req, " busy"}, busy, e != 0);
        if (e == 1) begin
            chk({req, " kind"}, fl_mass, 0);
            chk({req, " page"}, fl_page, m_page);
            m_page_arm = 0;
        end else if (e == 2) begin
            chk({req, " kind"}, fl_mass, 1);
            m_mass_arm = 0;
        end
    endtask

    task automatic finish_erase(input int wait_cyc, input string req);
        @(negedge clk);
        chk({req, " start single cycle"}, fl_start, 0);
        repeat (wait_cyc) begin
            @(negedge clk);
            chk({req, " busy held"}, busy, 1);
        end
        fl_done = 1'b1;
        @(negedge clk);
        fl_done = 1'b0;
        chk({req, " busy released"}, busy, 0);
    endtask

    // probe arms by attempting the commands
    task automatic probe_page(input string req);
        bit was = m_page_arm;
        cmd(8'h55, req);
        if (was) finish_erase(1, req);
    endtask

    task automatic probe_mass(input string req);
        bit was = m_mass_arm && debug_en;
        cmd(8'hAA, req);
        if (was) finish_erase(1, req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        chk("R7 busy", busy, 0);
        chk("R7 start", fl_start, 0);
        chk("R7 mass", fl_mass, 0);
        chk("R7 page", fl_page, 0);
        chk("R7 cmd_rdata", cmd_rdata, 0);
        debug_en = 1'b1;
        probe_mass("R7 mass unarmed");
        probe_page("R7 page unarmed");

        // R1, R4, R6 page erase
        arm_page(6'd63);
        cmd(8'h55, "R1 page erase");
        finish_erase(3, "R9 page");
        probe_page("R6 page arm consumed");
        arm_page(6'd0);
        cmd(8'h55, "R4 page zero");
        finish_erase(0, "R9 immediate done");

        // R2, R5 mass erase
        set_meen(1);
        debug_en = 1'b0;
        cmd(8'hAA, "R5 no debug");
        debug_en = 1'b1;
        cmd(8'hAA, "R2 mass erase");
        finish_erase(2, "R9 mass");
        probe_mass("R6 mass arm consumed");
        set_meen(1);
        set_meen(0);
        probe_mass("R5 cleared enable");

        // R3 other bytes keep arms
        arm_page(6'd21);
        set_meen(1);
        cmd(8'h54, "R3 wrong byte");
        cmd(8'h00, "R3 zero byte");
        cmd(8'hAB, "R10 readback");
        probe_page("R3 page arm kept");
        probe_mass("R3 mass arm kept");

        // R6 page erase leaves mass arm
        arm_page(6'd9);
        set_meen(1);
        probe_page("R6 page only");
        probe_mass("R6 mass survives");

        // R8 commands during busy
        arm_page(6'd40);
        set_meen(1);
        cmd(8'h55, "R8 first");
        arm_page(6'd41);
        wr(2'b00, 8'hAA); m_cmd = 8'hAA;
        chk("R8 no restart", fl_start, 0);
        chk("R10 readback while busy", cmd_rdata, 8'hAA);
        wr(2'b00, 8'h55);
        chk("R8 no restart page", fl_start, 0);
        finish_erase(1, "R8 busy");
        probe_page("R8 page arm kept");
        probe_mass("R8 mass arm kept");

        // R9 done while idle
        fl_done = 1'b1;
        @(negedge clk);
        fl_done = 1'b0;
        chk("R9 idle done", busy, 0);

        // random phase
        for (int i = 0; i < 300; i++) begin
            int op = $urandom_range(0, 5);
            case (op)
                0: arm_page(6'($urandom_range(0, 63)));
                1: set_meen(1'($urandom_range(0, 1)));
                2: debug_en = 1'($urandom_range(0, 1));
                3: cmd(8'h55, "R1 random");
                4: cmd(8'hAA, "R2 random");
                default: cmd(8'($urandom_range(0, 255)), "R3 random");
            endcase
            if (busy) finish_erase($urandom_range(0, 4), "R9 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule